// File: doc/BRIEF.md
# Masked-Write Pin Port Register Bank

This block holds the control state for one bank of 32 general-purpose pins, split into four ports of eight pins. Each port has a mode byte (pin under software control when set), a drive-enable byte, a drive-value byte, and a read-only level byte that reports the pad. A pin is pin number `port*8 + bit`. Software reaches the bytes over a plain 32-bit register bus with a combinational read path. Registers are one 32-bit word per port, four bytes apart. Only the low eight data bits carry register content.

Every control byte also appears a second time, at a fixed alias offset above the plain copy. A write through the alias treats data bits [15:8] as a per-bit select and data bits [7:0] as the new values. Only selected bits change, so one pin can be set or cleared without a read-modify-write sequence, and two agents cannot race each other on a shared byte. Pad levels pass through a two-stage synchroniser. The synchronised vector is also offered to a separate edge/level detector, which is not part of this block.

Top module: `pinbank_regs`

## Requirements
- R1: While reset is asserted, and after it is released, every mode, drive-enable and drive-value bit is 0. As a result `pad_oe` and `pad_out` are all 0, and every control register reads 0.
- R2: A write to a plain control register replaces the whole byte for that port. Mode registers are at 0x00, drive-enable at 0x10 and drive-value at 0x20, plus port*4. Read data bits [31:8] are always 0.
- R3: A write to the alias at 0x80 plus the plain offset updates only the bits whose select bit (data[15:8]) is 1, taking data[7:0] for those bits. All other bits keep their value. A select of 0x00 changes nothing.
- R4: A read of an alias address returns the same stored byte as the plain address.
- R5: `pad_oe[pin]` is 1 exactly when both the mode bit and the drive-enable bit of that pin are 1. `pad_out[pin]` equals the stored drive-value bit.
- R6: The level register at 0x30 plus port*4, and `pin_level`, show the `pad_in` value that was present two rising edges earlier. After only one edge, the previous value is still shown.
- R7: Writes to the level register, to 0x40–0x7F, to 0xB0–0xBF (there is no alias for the level register), or to any address not a multiple of 4 change no state. Reads of those unmapped addresses return 0.
- R8: A write to one port's register leaves the registers of the other three ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 8 | Byte address within the bank |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; [15:8] select in alias writes, [7:0] values |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Drive value per pin |
| pad_oe | output | 32 | Drive enable per pin |
| pin_level | output | 32 | Synchronised pad levels, for the interrupt detector |

## Verification
Random writes are spread over all three control groups and all four ports, in both plain and alias form. Random alias selects tell a true per-bit merge apart from a full-byte write or a write that ignores the select. Reads alternate between the plain and alias addresses, which exposes an alias read path that is decoded wrongly. Directed cases cover the all-zero and all-ones selects, a write to one port that must not leak into its neighbours, the one-edge and two-edge points of the synchroniser, and stores to the level, interrupt-area, missing-alias and misaligned addresses. Those stores must leave every byte unchanged.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  // Control and level groups; the index is the group offset divided by the group step.
  typedef enum logic [1:0] {
    GRP_MODE  = 2'd0,
    GRP_DRVEN = 2'd1,
    GRP_DRVAL = 2'd2,
    GRP_LEVEL = 2'd3
  } grp_e;

  localparam int NUM_CTL_GRPS  = 3;
  localparam int PORT_REG_STEP = 4;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CTL_GRPS-1:0]  wr_en,
  input  logic                     masked,
  input  logic [W-1:0]             wsel,
  input  logic [W-1:0]             wval,
  output logic [NUM_CTL_GRPS*W-1:0] regs_q
);
  logic [W-1:0] eff_sel;

  assign eff_sel = masked ? wsel : {W{1'b1}};

  for (genvar g = 0; g < NUM_CTL_GRPS; g++) begin : g_grp
    logic [W-1:0] byte_q;
    logic [W-1:0] byte_d;

    always_comb begin
      byte_d = (byte_q & ~eff_sel) | (wval & eff_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= '0;
      else if (wr_en[g]) byte_q <= byte_d;
    end

    assign regs_q[g*W +: W] = byte_q;
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int PORTS         = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int BANK_STRIDE   = 256,
  parameter int MASK_OFS      = 128,
  parameter int GROUP_STEP    = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int DATA_W        = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(BANK_STRIDE)-1:0]      bus_addr,
  input  logic                                bus_we,
  input  logic [DATA_W-1:0]                   bus_wdata,
  output logic [DATA_W-1:0]                   bus_rdata,
  input  logic [PORTS*PINS_PER_PORT-1:0]      pad_in,
  output logic [PORTS*PINS_PER_PORT-1:0]      pad_out,
  output logic [PORTS*PINS_PER_PORT-1:0]      pad_oe,
  output logic [PORTS*PINS_PER_PORT-1:0]      pin_level
);
  localparam int PPP    = PINS_PER_PORT;
  localparam int PINS   = PORTS * PPP;
  localparam int REGW   = NUM_CTL_GRPS * PPP;

  // ---------------- address decode ----------------
  logic [31:0] a_full, rel, grp_idx, prt_idx;
  logic        in_alias, addr_ok, hit_ctl, hit_lvl;

  always_comb begin
    a_full   = 32'(bus_addr);
    in_alias = (a_full >= 32'(MASK_OFS)) && (a_full < 32'(2 * MASK_OFS));
    rel      = in_alias ? (a_full - 32'(MASK_OFS)) : a_full;
    grp_idx  = rel / 32'(GROUP_STEP);
    prt_idx  = (rel % 32'(GROUP_STEP)) / 32'(PORT_REG_STEP);
    addr_ok  = (rel % 32'(PORT_REG_STEP) == 32'd0) && (prt_idx < 32'(PORTS))
               && (rel < 32'(MASK_OFS));
    hit_ctl  = addr_ok && (grp_idx < 32'(NUM_CTL_GRPS));
    hit_lvl  = addr_ok && (grp_idx == 32'(GRP_LEVEL)) && !in_alias;
  end

  // ---------------- per-port register sets ----------------
  logic [NUM_CTL_GRPS-1:0] port_wr  [PORTS];
  logic [REGW-1:0]         port_regs[PORTS];
  logic [PINS-1:0]         lvl_sync;

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      for (int g = 0; g < NUM_CTL_GRPS; g++) begin
        port_wr[p][g] = bus_we && hit_ctl && (prt_idx == 32'(p)) && (grp_idx == 32'(g));
      end
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    pinbank_port #(.W(PPP)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (port_wr[p]),
      .masked (in_alias),
      .wsel   (bus_wdata[2*PPP-1:PPP]),
      .wval   (bus_wdata[PPP-1:0]),
      .regs_q (port_regs[p])
    );

    logic [PPP-1:0] mode_b, en_b, val_b;
    assign mode_b = port_regs[p][int'(GRP_MODE)*PPP  +: PPP];
    assign en_b   = port_regs[p][int'(GRP_DRVEN)*PPP +: PPP];
    assign val_b  = port_regs[p][int'(GRP_DRVAL)*PPP +: PPP];

    assign pad_oe [p*PPP +: PPP] = mode_b & en_b;
    assign pad_out[p*PPP +: PPP] = val_b;
  end

  // ---------------- pad synchroniser ----------------
  pinbank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_in),
    .q_o   (lvl_sync)
  );

  assign pin_level = lvl_sync;

  // ---------------- read mux ----------------
  logic [PPP-1:0] rd_byte;

  always_comb begin
    rd_byte = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (prt_idx == 32'(p)) begin
        if (hit_ctl) begin
          for (int g = 0; g < NUM_CTL_GRPS; g++) begin
            if (grp_idx == 32'(g)) rd_byte = port_regs[p][g*PPP +: PPP];
          end
        end else if (hit_lvl) begin
          rd_byte = lvl_sync[p*PPP +: PPP];
        end
      end
    end
    bus_rdata = '0;
    bus_rdata[PPP-1:0] = rd_byte;
  end
endmodule

// File: rtl/pinbank_regs_chk.sv
module pinbank_regs_chk #(
  parameter int ADDR_W     = 8,
  parameter int PINS       = 32,
  parameter int DATA_W     = 32,
  parameter int MASK_OFS   = 128,
  parameter int GROUP_STEP = 16,
  parameter int PPP        = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pin_level
);
  logic [1:0]  since_rst;
  logic [31:0] a;
  logic        a_unmapped, a_level, a_val_alias;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    a           = 32'(bus_addr);
    a_unmapped  = (a >= 32'(4 * GROUP_STEP)) && (a < 32'(MASK_OFS));
    a_level     = (a >= 32'(3 * GROUP_STEP)) && (a < 32'(4 * GROUP_STEP));
    a_val_alias = (a >= 32'(MASK_OFS + 2 * GROUP_STEP)) && (a < 32'(MASK_OFS + 3 * GROUP_STEP));
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0));

  assert_rdata_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PPP] == '0);

  assert_zero_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) && bus_we && a_val_alias && (bus_wdata[2*PPP-1:PPP] == '0)
    |=> $stable(pad_out));

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (pin_level == $past(pad_in, 2)));

  assert_no_write_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) && !bus_we |=> $stable(pad_oe) && $stable(pad_out));

  assert_level_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) && bus_we && (a_level || a_unmapped) |=> $stable(pad_oe) && $stable(pad_out));

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_unmapped |-> (bus_rdata == '0));
endmodule

bind pinbank_regs pinbank_regs_chk #(
  .ADDR_W($clog2(BANK_STRIDE)), .PINS(PORTS*PINS_PER_PORT), .DATA_W(DATA_W),
  .MASK_OFS(MASK_OFS), .GROUP_STEP(GROUP_STEP), .PPP(PINS_PER_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level)
);

// File: tb/pinbank_regs_bench.sv
`timescale 1ns/1ps
module pinbank_regs_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in, pad_out, pad_oe, pin_level;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_reg [3][4];   // [group][port] model: 0 mode, 1 drive enable, 2 drive value

  pinbank_regs u_pinbank_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_oe();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[0][p] & m_reg[1][p];
    return v;
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] v;
    for (int p = 0; p < 4; p++) v[p*8 +: 8] = m_reg[2][p];
    return v;
  endfunction

  function automatic logic [7:0] reg_addr(input int grp, input int port, input bit alias_f);
    return 8'((alias_f ? 128 : 0) + grp * 16 + port * 4);
  endfunction

  task automatic bus_wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_we = 1'b0;
    #1 data = bus_rdata;
  endtask

  task automatic ctl_wr(input int grp, input int port, input bit alias_f, input logic [15:0] d);
    logic [7:0] sel;
    bus_wr(reg_addr(grp, port, alias_f), {16'h0, d});
    sel = alias_f ? d[15:8] : 8'hFF;
    m_reg[grp][port] = (m_reg[grp][port] & ~sel) | (d[7:0] & sel);
  endtask

  task automatic check_all(input string req);
    logic [31:0] r;
    for (int g = 0; g < 3; g++)
      for (int p = 0; p < 4; p++) begin
        bus_rd(reg_addr(g, p, 1'b0), r);
        check(req, r, {24'h0, m_reg[g][p]});
      end
    check(req, pad_oe, exp_oe());
    check(req, pad_out, exp_out());
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] seed_val;
    logic [31:0] old_pad, new_pad;
    seed_val = $urandom(32'h1d2c3b4a);
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    for (int g = 0; g < 3; g++) for (int p = 0; p < 4; p++) m_reg[g][p] = 8'h00;

    // R1: outputs during reset
    #12;
    check("R1", pad_oe, 32'h0);
    check("R1", pad_out, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");

    // R2: plain full-byte write; R8: neighbours untouched
    ctl_wr(0, 1, 1'b0, 16'hFFA5);
    ctl_wr(1, 1, 1'b0, 16'h00F0);
    ctl_wr(2, 1, 1'b0, 16'h003C);
    check_all("R2_R8");
    bus_rd(reg_addr(0, 1, 1'b0), r);
    check("R2", r, 32'h0000_00A5);
    check("R5", pad_oe, 32'h0000_A000);
    check("R5", pad_out, 32'h0000_3C00);

    // R3: select 0x00 changes nothing, select 0xFF is a full write, partial merge
    ctl_wr(2, 1, 1'b1, 16'h00FF);
    check("R3", pad_out, 32'h0000_3C00);
    ctl_wr(2, 3, 1'b1, 16'hFF81);
    check("R3", pad_out, 32'h8100_3C00);
    ctl_wr(2, 1, 1'b1, 16'h0F0A);
    check("R3", pad_out, 32'h8100_3A00);

    // R4: alias read matches plain read
    bus_rd(reg_addr(2, 1, 1'b1), r);
    check("R4", r, 32'h0000_003A);

    // R6: synchroniser depth
    @(negedge clk); pad_in = 32'h1111_2222;
    repeat (3) @(negedge clk);
    old_pad = pad_in;
    new_pad = 32'hC3A5_5A3C;
    @(negedge clk); pad_in = new_pad;
    @(posedge clk); #1 check("R6", pin_level, old_pad);
    @(posedge clk); #1 check("R6", pin_level, new_pad);
    for (int p = 0; p < 4; p++) begin
      bus_rd(reg_addr(3, p, 1'b0), r);
      check("R6", r, {24'h0, new_pad[p*8 +: 8]});
    end

    // R7: stores to level, interrupt area, missing alias, misaligned
    bus_wr(8'h30, 32'h0000_FFFF);
    bus_wr(8'h44, 32'h0000_FFFF);
    bus_wr(8'h7C, 32'h0000_FFFF);
    bus_wr(8'hB0, 32'h0000_FFFF);
    bus_wr(8'h21, 32'h0000_FFFF);
    bus_wr(8'hA6, 32'h0000_FFFF);
    check_all("R7");
    bus_rd(8'h44, r);  check("R7", r, 32'h0);
    bus_rd(8'hB4, r);  check("R7", r, 32'h0);
    bus_rd(8'h22, r);  check("R7", r, 32'h0);

    // Random mix: R2, R3, R4, R5, R8
    for (int i = 0; i < 400; i++) begin
      int g, p;
      bit al;
      logic [15:0] d;
      g  = int'($urandom_range(2, 0));
      p  = int'($urandom_range(3, 0));
      al = 1'($urandom_range(1, 0));
      d  = 16'($urandom);
      ctl_wr(g, p, al, d);
      check(al ? "R3" : "R2", pad_out, exp_out());
      check("R5", pad_oe, exp_oe());
      g = int'($urandom_range(2, 0));
      p = int'($urandom_range(3, 0));
      al = 1'($urandom_range(1, 0));
      bus_rd(reg_addr(g, p, al), r);
      check(al ? "R4" : "R8", r, {24'h0, m_reg[g][p]});
      if (i % 50 == 0) begin
        logic [31:0] v;
        v = $urandom;
        @(negedge clk); pad_in = v;
        @(negedge clk); @(negedge clk);
        check("R6", pin_level, v);
      end
    end
    check_all("R8");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule